// File: doc/BRIEF.md
# Sensor Node Command Controller

This block is the top-level sequencer of a passive, hub-powered sensor node. It sits idle listening for commands that an upstream receiver has already demodulated, and for each accepted command it performs exactly one job: fetch a sample from the sensor, forward a byte relayed from a neighbouring node into local storage, stream all stored bytes out to the transmitter, empty the store, or put the node to sleep. Once the job is complete it goes back to listening. The block keeps no routing state and does no error checking.

Local sample storage lives outside the block. It is organised as fixed-size banks. Bank 0 is always powered. Each further bank has its own power enable, driven by this block. An enable is raised only when a byte has to land in that bank, and it stays raised until the store is emptied. The state register walks a Gray-coded cycle, so each step flips one state bit.

Top module: `node_cmd_ctrl`

## Requirements
- R1: After reset the controller is listening: `sns_req`, `mem_we`, `tx_valid`, `mem_full`, `sleep` and every bit of `bank_pwr` are 0.
- R2: An accepted command passes through listen, decode, execute and done states coded 00, 01, 11, 10, one clock each unless execute waits. A relay store therefore drives `mem_we` during the second cycle after the edge that samples `cmd_valid`.
- R3: The opcodes on `cmd_op` are 1 measure, 2 transmit, 3 relay store, 4 clear, 5 power down. The codes 0, 6 and 7 are ignored: nothing is written, nothing is sent and no flag changes.
- R4: Measure holds `sns_req` high until `sns_ack` is seen. In the cycle of the acknowledge it writes `sns_byte` at the address equal to the number of bytes already stored.
- R5: Relay store writes the `cmd_byte` value sampled together with the command at the next free address.
- R6: Bit k-1 of `bank_pwr` rises when the byte to be stored is byte number k*BANK_BYTES+1, counting from 1. This is the 17th byte for bank 1 with the defaults. It is high before that write and never rises earlier.
- R7: Once raised, a bank enable stays high until a clear or power down command executes. Clear empties the store and drops both `mem_full` and every bank enable.
- R8: Transmit presents the stored bytes on `tx_data` with `tx_valid`, one per clock in write order, and raises `tx_last` only with the final byte. The store is not emptied, so a second transmit repeats the same sequence.
- R9: A measure or relay store issued when all banks are full writes nothing, raises no `sns_req`, and sets `mem_full`.
- R10: Power down sets `sleep` and drops every bank enable. From then on every command is ignored until reset.
- R11: Transmit with an empty store sends no byte and returns to listening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a command |
| cmd_op | input | 3 | Command opcode |
| cmd_byte | input | DATA_W | Relayed data byte for relay store |
| sns_req | output | 1 | Sensor sample request |
| sns_ack | input | 1 | Sensor sample ready |
| sns_byte | input | DATA_W | Sensor sample value |
| mem_we | output | 1 | Storage write strobe |
| mem_waddr | output | $clog2(BANKS*BANK_BYTES) | Storage write address |
| mem_wdata | output | DATA_W | Storage write data |
| mem_raddr | output | $clog2(BANKS*BANK_BYTES) | Storage read address |
| mem_rdata | input | DATA_W | Storage read data, combinational from mem_raddr |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | DATA_W | Transmit byte |
| tx_last | output | 1 | Final byte of a transmit burst |
| bank_pwr | output | BANKS-1 | Power enables of banks 1 and up |
| mem_full | output | 1 | A store request was refused because storage is full |
| sleep | output | 1 | Node powered down until reset |

## Verification
The assertions assume that `mem_rdata` returns, in the same cycle, the byte last written at `mem_raddr`. They also assume that `sns_ack` matters only while `sns_req` is high, and that a new `cmd_valid` arrives only after the previous command has returned to listening. The bench meets these assumptions in three ways. Its memory model is an array read combinationally. Its sensor answers only through a gate on `sns_req`. Every command task waits out the full decode, execute and done sequence, plus the length of a transmit burst, before it drives the next strobe.

// File: rtl/node_cmd_pkg.sv
package node_cmd_pkg;
   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_MEASURE = 3'd1,
      OP_SEND    = 3'd2,
      OP_RELAY   = 3'd3,
      OP_ERASE   = 3'd4,
      OP_SLEEP   = 3'd5
   } op_e;

   // Gray walk: each normal step flips one bit
   typedef enum logic [1:0] {
      ST_LISTEN = 2'b00,
      ST_DECODE = 2'b01,
      ST_EXEC   = 2'b11,
      ST_DONE   = 2'b10
   } st_e;

   function automatic logic op_known(input logic [2:0] o);
      return (o >= 3'd1) && (o <= 3'd5);
   endfunction
endpackage

// File: rtl/node_fill_tracker.sv
module node_fill_tracker #(
   parameter int BANK_BYTES = 16,
   parameter int BANKS      = 2,
   parameter int CW         = $clog2(BANKS*BANK_BYTES+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_strobe,
   input  logic             grow_req,
   input  logic             erase,
   input  logic             sleep_req,
   input  logic             refuse,
   output logic [CW-1:0]    fill,
   output logic             is_full,
   output logic             mem_full,
   output logic [BANKS-2:0] bank_en
);
   localparam int CAP = BANKS * BANK_BYTES;
   localparam logic [CW-1:0] CAP_V = CW'(CAP);

   assign is_full = (fill == CAP_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill     <= '0;
         mem_full <= 1'b0;
      end else begin
         if (erase)                      fill <= '0;
         else if (wr_strobe && !is_full) fill <= fill + CW'(1);
         if (erase)       mem_full <= 1'b0;
         else if (refuse) mem_full <= 1'b1;
      end
   end

   for (genvar k = 1; k < BANKS; k++) begin : g_bank
      localparam logic [CW-1:0] TH = CW'(k * BANK_BYTES);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      bank_en[k-1] <= 1'b0;
         else if (erase || sleep_req)     bank_en[k-1] <= 1'b0;
         else if (grow_req && fill >= TH) bank_en[k-1] <= 1'b1;
      end

      a_r6_bank_rise_needs_fill : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bank_en[k-1]) |-> fill >= TH);
      a_r7_bank_held : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(bank_en[k-1]) |-> ($past(erase) || $past(sleep_req)));
   end

   a_r9_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CAP_V);
endmodule

// File: rtl/node_cmd_fsm.sv
module node_cmd_fsm
   import node_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int AW     = 5,
   parameter int CW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_byte,
   output logic              sns_req,
   input  logic              sns_ack,
   input  logic [DATA_W-1:0] sns_byte,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [AW-1:0]     mem_raddr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   input  logic [CW-1:0]     fill,
   input  logic              is_full,
   output logic              grow_req,
   output logic              erase,
   output logic              sleep_req,
   output logic              refuse,
   output logic              asleep
);
   st_e               state, state_n;
   op_e               op_q;
   logic [DATA_W-1:0] byte_q;
   logic [CW-1:0]     rd_ptr, rd_ptr_n;
   logic              is_write;

   assign is_write  = (op_q == OP_MEASURE) || (op_q == OP_RELAY);
   assign mem_waddr = fill[AW-1:0];
   assign mem_raddr = rd_ptr[AW-1:0];
   assign tx_data   = mem_rdata;

   always_comb begin
      state_n   = state;
      rd_ptr_n  = rd_ptr;
      sns_req   = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = byte_q;
      tx_valid  = 1'b0;
      tx_last   = 1'b0;
      grow_req  = 1'b0;
      erase     = 1'b0;
      sleep_req = 1'b0;
      refuse    = 1'b0;
      unique case (state)
         ST_LISTEN: if (cmd_valid && !asleep && op_known(cmd_op)) state_n = ST_DECODE;
         ST_DECODE: begin
            grow_req = is_write && !is_full;
            state_n  = ST_EXEC;
         end
         ST_EXEC: begin
            case (op_q)
               OP_MEASURE: begin
                  if (is_full) begin
                     refuse  = 1'b1;
                     state_n = ST_DONE;
                  end else begin
                     sns_req   = 1'b1;
                     mem_wdata = sns_byte;
                     if (sns_ack) begin
                        mem_we  = 1'b1;
                        state_n = ST_DONE;
                     end
                  end
               end
               OP_RELAY: begin
                  if (is_full) refuse = 1'b1;
                  else         mem_we = 1'b1;
                  state_n = ST_DONE;
               end
               OP_SEND: begin
                  if (fill == '0) begin
                     state_n = ST_DONE;
                  end else begin
                     tx_valid = 1'b1;
                     if (rd_ptr == fill - CW'(1)) begin
                        tx_last  = 1'b1;
                        rd_ptr_n = '0;
                        state_n  = ST_DONE;
                     end else begin
                        rd_ptr_n = rd_ptr + CW'(1);
                     end
                  end
               end
               OP_ERASE: begin
                  erase   = 1'b1;
                  state_n = ST_DONE;
               end
               default: begin
                  sleep_req = 1'b1;
                  state_n   = ST_DONE;
               end
            endcase
         end
         default: state_n = ST_LISTEN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_LISTEN;
         op_q   <= OP_NONE;
         byte_q <= '0;
         rd_ptr <= '0;
         asleep <= 1'b0;
      end else begin
         state  <= state_n;
         rd_ptr <= rd_ptr_n;
         if (state == ST_LISTEN && state_n == ST_DECODE) begin
            op_q   <= op_e'(cmd_op);
            byte_q <= cmd_byte;
         end
         if (sleep_req) asleep <= 1'b1;
      end
   end

   a_r2_gray_step : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state ^ $past(state)) <= 1);
   a_r10_sleep_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      $past(asleep) |-> asleep);
   a_r8_last_with_valid : assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);
   a_r9_no_write_when_full : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !is_full);
   a_r4_ack_only_on_req : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && op_q == OP_MEASURE) |-> sns_req);
endmodule

// File: rtl/node_cmd_ctrl.sv
module node_cmd_ctrl #(
   parameter int DATA_W     = 8,
   parameter int BANK_BYTES = 16,
   parameter int BANKS      = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cmd_valid,
   input  logic [2:0]                             cmd_op,
   input  logic [DATA_W-1:0]                      cmd_byte,
   output logic                                   sns_req,
   input  logic                                   sns_ack,
   input  logic [DATA_W-1:0]                      sns_byte,
   output logic                                   mem_we,
   output logic [$clog2(BANKS*BANK_BYTES)-1:0]    mem_waddr,
   output logic [DATA_W-1:0]                      mem_wdata,
   output logic [$clog2(BANKS*BANK_BYTES)-1:0]    mem_raddr,
   input  logic [DATA_W-1:0]                      mem_rdata,
   output logic                                   tx_valid,
   output logic [DATA_W-1:0]                      tx_data,
   output logic                                   tx_last,
   output logic [BANKS-2:0]                       bank_pwr,
   output logic                                   mem_full,
   output logic                                   sleep
);
   localparam int CAP = BANKS * BANK_BYTES;
   localparam int AW  = $clog2(CAP);
   localparam int CW  = $clog2(CAP + 1);

   if (BANKS < 2) begin : g_bad_banks
      $error("node_cmd_ctrl: BANKS must be at least 2");
   end
   if (BANK_BYTES < 2) begin : g_bad_bank_bytes
      $error("node_cmd_ctrl: BANK_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("node_cmd_ctrl: DATA_W must be positive");
   end

   logic [CW-1:0] fill;
   logic          is_full, grow_req, erase, sleep_req, refuse;

   node_cmd_fsm #(.DATA_W(DATA_W), .AW(AW), .CW(CW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
      .sns_req(sns_req), .sns_ack(sns_ack), .sns_byte(sns_byte),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .fill(fill), .is_full(is_full), .grow_req(grow_req),
      .erase(erase), .sleep_req(sleep_req), .refuse(refuse), .asleep(sleep)
   );

   node_fill_tracker #(.BANK_BYTES(BANK_BYTES), .BANKS(BANKS), .CW(CW)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .wr_strobe(mem_we), .grow_req(grow_req), .erase(erase),
      .sleep_req(sleep_req), .refuse(refuse),
      .fill(fill), .is_full(is_full), .mem_full(mem_full), .bank_en(bank_pwr)
   );

   a_r10_sleep_gates_off : assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (bank_pwr == '0));
   a_r1_idle_when_asleep : assert property (@(posedge clk) disable iff (!rst_n)
      $past(sleep) |-> !(mem_we || tx_valid || sns_req));
endmodule

// File: tb/sim_node_cmd_ctrl.sv
module sim_node_cmd_ctrl;
   localparam int DW = 8;
   localparam int BB = 16;
   localparam int NB = 2;
   localparam int CAP = NB * BB;
   localparam int AW = $clog2(CAP);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [DW-1:0] cmd_byte = '0, sns_byte = '0;
   logic sns_req, sns_ack, ack_en = 1'b1;
   logic mem_we, tx_valid, tx_last, mem_full, sleep;
   logic [AW-1:0] mem_waddr, mem_raddr;
   logic [DW-1:0] mem_wdata, mem_rdata, tx_data;
   logic [NB-2:0] bank_pwr;

   logic [DW-1:0] mem_model [CAP];
   logic [DW-1:0] exp_mem [CAP];
   int exp_n = 0;
   logic [DW-1:0] rx_buf [64];
   int rx_n = 0, last_pos = -1, last_cnt = 0;
   int we_cnt = 0, req_cnt = 0;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   assign sns_ack   = sns_req & ack_en;
   assign mem_rdata = mem_model[mem_raddr];

   always @(posedge clk) begin
      if (mem_we) begin
         mem_model[mem_waddr] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (sns_req) req_cnt <= req_cnt + 1;
   end

   always @(negedge clk) begin
      if (tx_valid) begin
         rx_buf[rx_n] = tx_data;
         if (tx_last) begin
            last_pos = rx_n;
            last_cnt = last_cnt + 1;
         end
         rx_n = rx_n + 1;
      end
   end

   node_cmd_ctrl #(.DATA_W(DW), .BANK_BYTES(BB), .BANKS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_byte(cmd_byte), .sns_req(sns_req), .sns_ack(sns_ack),
      .sns_byte(sns_byte), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .bank_pwr(bank_pwr), .mem_full(mem_full), .sleep(sleep)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [DW-1:0] b, input int wait_cyc);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_byte = b;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
      repeat (wait_cyc) @(negedge clk);
   endtask

   task automatic relay(input logic [DW-1:0] b);
      issue(3'd3, b, 5);
      if (exp_n < CAP) begin exp_mem[exp_n] = b; exp_n++; end
   endtask

   task automatic send_and_check(input string req);
      rx_n = 0; last_pos = -1; last_cnt = 0;
      issue(3'd2, 8'h00, exp_n + 6);
      chk(rx_n == exp_n, req, rx_n, exp_n);
      for (int i = 0; i < exp_n; i++)
         chk(rx_buf[i] == exp_mem[i], req, int'(rx_buf[i]), int'(exp_mem[i]));
      if (exp_n > 0) begin
         chk(last_pos == exp_n - 1, req, last_pos, exp_n - 1);
         chk(last_cnt == 1, req, last_cnt, 1);
      end
   endtask

   // {op, data, exp_mem_full, exp_bank_pwr, writes}
   localparam int NV = 6;
   localparam logic [13:0] VEC [NV] = '{
      {3'd3, 8'h11, 1'b0, 1'b0, 1'b1},
      {3'd6, 8'hE6, 1'b0, 1'b0, 1'b0},
      {3'd7, 8'hE7, 1'b0, 1'b0, 1'b0},
      {3'd0, 8'hE0, 1'b0, 1'b0, 1'b0},
      {3'd1, 8'h5A, 1'b0, 1'b0, 1'b1},
      {3'd3, 8'h22, 1'b0, 1'b0, 1'b1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({sns_req, mem_we, tx_valid, mem_full, sleep, bank_pwr} == '0, "R1", 1, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({sns_req, mem_we, tx_valid, mem_full, sleep, bank_pwr} == '0, "R1", 1, 0);

      // table walk: R3 opcodes and ignored codes, R4/R5 writes
      for (int v = 0; v < NV; v++) begin
         w0 = we_cnt;
         sns_byte = VEC[v][10:3];
         issue(VEC[v][13:11], VEC[v][10:3], 5);
         if (VEC[v][0]) begin exp_mem[exp_n] = VEC[v][10:3]; exp_n++; end
         chk(we_cnt - w0 == int'(VEC[v][0]), "R3", we_cnt - w0, int'(VEC[v][0]));
         chk(mem_full == VEC[v][2], "R3", mem_full, VEC[v][2]);
         chk(bank_pwr[0] == VEC[v][1], "R3", bank_pwr[0], VEC[v][1]);
      end
      send_and_check("R8");

      // R2 timing of a relay write, R5 data and address
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd3; cmd_byte = 8'h7C;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0; cmd_byte = 8'h00;
      chk(mem_we == 1'b0, "R2", mem_we, 0);
      @(negedge clk);
      chk(mem_we == 1'b1, "R2", mem_we, 1);
      chk(mem_wdata == 8'h7C, "R5", mem_wdata, 8'h7C);
      chk(mem_waddr == AW'(exp_n), "R5", mem_waddr, exp_n);
      exp_mem[exp_n] = 8'h7C; exp_n++;
      repeat (4) @(negedge clk);

      // R4 delayed acknowledge
      ack_en = 1'b0; sns_byte = 8'hB3;
      w0 = we_cnt;
      issue(3'd1, 8'h00, 5);
      chk(sns_req == 1'b1, "R4", sns_req, 1);
      chk(we_cnt == w0, "R4", we_cnt - w0, 0);
      ack_en = 1'b1;
      repeat (4) @(negedge clk);
      chk(we_cnt == w0 + 1, "R4", we_cnt - w0, 1);
      chk(sns_req == 1'b0, "R4", sns_req, 0);
      exp_mem[exp_n] = 8'hB3; exp_n++;

      // R6 fill to one bank, then the 17th byte
      while (exp_n < BB) relay(8'(8'h80 + exp_n));
      chk(bank_pwr[0] == 1'b0, "R6", bank_pwr[0], 0);
      relay(8'hC1);
      chk(bank_pwr[0] == 1'b1, "R6", bank_pwr[0], 1);
      while (exp_n < CAP) relay(8'(8'h40 + exp_n));
      chk(mem_full == 1'b0, "R9", mem_full, 0);

      // R9 refused stores
      w0 = we_cnt;
      issue(3'd3, 8'hEE, 5);
      chk(we_cnt == w0, "R9", we_cnt - w0, 0);
      chk(mem_full == 1'b1, "R9", mem_full, 1);
      w0 = req_cnt;
      issue(3'd1, 8'h00, 5);
      chk(req_cnt == w0, "R9", req_cnt - w0, 0);

      // R8 full stream twice, R7 bank held
      send_and_check("R8");
      send_and_check("R8");
      chk(bank_pwr[0] == 1'b1, "R7", bank_pwr[0], 1);

      // R7 clear, R11 empty transmit
      issue(3'd4, 8'h00, 5);
      exp_n = 0;
      chk(bank_pwr[0] == 1'b0, "R7", bank_pwr[0], 0);
      chk(mem_full == 1'b0, "R7", mem_full, 0);
      send_and_check("R11");
      chk(rx_n == 0, "R11", rx_n, 0);

      // R10 power down with bank 1 on
      while (exp_n < BB + 1) relay(8'(8'h10 + exp_n));
      chk(bank_pwr[0] == 1'b1, "R10", bank_pwr[0], 1);
      issue(3'd5, 8'h00, 5);
      chk(sleep == 1'b1, "R10", sleep, 1);
      chk(bank_pwr[0] == 1'b0, "R10", bank_pwr[0], 0);
      w0 = we_cnt; rx_n = 0;
      issue(3'd3, 8'h99, 5);
      issue(3'd2, 8'h00, 25);
      issue(3'd4, 8'h00, 5);
      chk(we_cnt == w0, "R10", we_cnt - w0, 0);
      chk(rx_n == 0, "R10", rx_n, 0);
      chk(sleep == 1'b1, "R10", sleep, 1);

      // R1 reset leaves sleep
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sleep, mem_full, bank_pwr} == '0, "R1", sleep, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule